// File: doc/BRIEF.md
# Keyed Independent Watchdog

This block is a watchdog timer whose 12-bit down-counter runs on a slow, free-running clock. The slow clock first passes through a prescaler. Software talks to the block through a small write port on the fast bus clock. A key register gates every action. One key opens the configuration registers. A second key starts the counter for good. A third key refreshes the counter. Any other key value closes the configuration registers again.

The prescaler, reload and window settings are held in bus-clock registers and are moved into the slow domain by a handshake. A three-bit status vector shows, for each register, that a move is still in flight. If the counter runs out, the block raises a reset request that lasts one slow cycle. It does the same if a refresh arrives while the counter is still above the window value. Once started, the watchdog keeps running until the system reset.

Top module: `keyed_wdt`

## Requirements
- R1: The write port selects a register with `wr_addr`: 0 key, 1 prescaler, 2 reload, 3 window. Writes to addresses 1 to 3 are accepted only after key 16'h5555 has been written. Any key other than 16'h5555 closes them again, and a write to a closed register leaves the registers and `busy_o` unchanged.
- R2: Key 16'hCCCC starts the watchdog. `running_o` rises within a few slow cycles and stays high until `rst_n` is asserted. Any further key write, including 16'h5555, does not clear it. This key also closes the configuration registers.
- R3: While running and not refreshed, `wdt_rst_o` pulses once every (reload+1) × (4 << prescaler) slow cycles.
- R4: The prescaler field is 3 bits wide, and the counter advances once every 4 << field slow cycles: 4 for field 0, 8 for field 1, up to 512 for field 7.
- R5: Key 16'hAAAA, written while the counter is at or below the window value, reloads the counter with the reload value and restarts the prescaler. This postpones the next reset pulse by a full period.
- R6: Key 16'hAAAA, written while the counter is above the window value, causes an immediate reset pulse. A window value of 12'hFFF never triggers this.
- R7: `busy_o` bit 0 belongs to the prescaler, bit 1 to the reload and bit 2 to the window. An accepted write sets its bit on the next bus clock edge. The bit clears once the value has reached the slow domain and the acknowledge has come back, and `busy_o` then reads zero.
- R8: A write to a configuration register whose busy bit is set is dropped, and the pending value is kept.
- R9: After reset, the prescaler field is 0, the reload value is 12'hFFF, the window value is 12'hFFF, `busy_o` is 0, `running_o` is 0 and `wdt_rst_o` is 0. Started from this state, the first pulse comes about 16384 slow cycles after the start key.
- R10: Every reset pulse lasts exactly one slow clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, synchronous in both domains |
| slow_clk | input | 1 | Free-running slow clock that times the watchdog |
| wr_en | input | 1 | Register write strobe (bus clock) |
| wr_addr | input | 2 | Register select: 0 key, 1 prescaler, 2 reload, 3 window |
| wr_data | input | 16 | Write data |
| busy_o | output | 3 | Transfer-in-flight flags: bit 0 prescaler, bit 1 reload, bit 2 window |
| running_o | output | 1 | Watchdog started (slow domain) |
| wdt_rst_o | output | 1 | One-slow-cycle reset request |

## Verification
A busy bit is due one bus edge after an accepted write. The bench reads it at the next falling bus edge and then polls with a bound until it clears. Reset pulses are registered one slow edge after the count or refresh decides, so the bench timestamps them at falling slow edges. Periods are measured between two pulses well after any configuration change, which makes them exact. Latencies that cross the clock boundary (start, refresh) take a few synchronizer cycles, so those checks use windows placed well clear of the next natural timeout.

// File: rtl/wdg_pkg.sv
// Shared constants for the keyed watchdog: key codes, register
// selector encoding and status-channel indices.
package wdg_pkg;
    localparam int KEY_W = 16;
    localparam int N_CH  = 3;
    localparam int CH_PR  = 0;
    localparam int CH_RL  = 1;
    localparam int CH_WIN = 2;

    localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;
    localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;

    typedef enum logic [1:0] {
        SEL_KEY    = 2'd0,
        SEL_PRESC  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_WINDOW = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/wdg_sync.sv
// Multi-flop synchronizer for a vector of independent toggle bits.
// Assumes each bit changes at most once per several destination cycles
// (toggle handshakes), so bits need no mutual coherence.
module wdg_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    // Shift the asynchronous input through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/wdg_bus_if.sv
// Bus-clock side of the watchdog: key decoding, lock state, shadow
// registers and one toggle handshake per configuration register.
// Assumes the slow side copies a shadow only while its busy bit is set,
// during which the shadow is held stable.
module wdg_bus_if
    import wdg_pkg::*;
#(
    parameter int PR_W        = 3,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [KEY_W-1:0]  wr_data,
    input  logic [N_CH-1:0]   ack_tgl_i,
    output logic [N_CH-1:0]   req_tgl_o,
    output logic              start_tgl_o,
    output logic              refresh_tgl_o,
    output logic [PR_W-1:0]   pr_o,
    output logic [CNT_W-1:0]  rl_o,
    output logic [CNT_W-1:0]  win_o,
    output logic [N_CH-1:0]   busy_o,
    output logic              unlocked_o
);
    logic [N_CH-1:0] ack_s;
    logic [N_CH-1:0] req_tgl_q;
    logic [N_CH-1:0] accept;
    logic            unlocked_q;
    logic            started_q;
    logic            start_tgl_q;
    logic            refresh_tgl_q;
    logic            key_wr;

    wdg_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl_i),
        .q     (ack_s)
    );

    assign busy_o = req_tgl_q ^ ack_s;
    assign key_wr = wr_en && (wr_addr == SEL_KEY);

    // Accept a configuration write only when open and its channel is idle.
    always_comb begin
        for (int i = 0; i < N_CH; i++) begin
            accept[i] = wr_en && (wr_addr == 2'(i + 1)) && unlocked_q && !busy_o[i];
        end
    end

    // Key handling: lock state, one-shot start, refresh toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unlocked_q    <= 1'b0;
            started_q     <= 1'b0;
            start_tgl_q   <= 1'b0;
            refresh_tgl_q <= 1'b0;
        end else if (key_wr) begin
            unlocked_q <= (wr_data == KEY_UNLOCK);
            if (wr_data == KEY_START && !started_q) begin
                started_q   <= 1'b1;
                start_tgl_q <= ~start_tgl_q;
            end
            if (wr_data == KEY_REFRESH) begin
                refresh_tgl_q <= ~refresh_tgl_q;
            end
        end
    end

    // Shadow registers and their request toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tgl_q <= '0;
            pr_o      <= '0;
            rl_o      <= '1;
            win_o     <= '1;
        end else begin
            req_tgl_q <= req_tgl_q ^ accept;
            if (accept[CH_PR])  pr_o  <= wr_data[PR_W-1:0];
            if (accept[CH_RL])  rl_o  <= wr_data[CNT_W-1:0];
            if (accept[CH_WIN]) win_o <= wr_data[CNT_W-1:0];
        end
    end

    assign req_tgl_o     = req_tgl_q;
    assign start_tgl_o   = start_tgl_q;
    assign refresh_tgl_o = refresh_tgl_q;
    assign unlocked_o    = unlocked_q;
endmodule

// File: rtl/wdg_prescaler.sv
// Slow-clock prescaler producing one tick every (4 << pr) cycles.
// A clear restarts the phase; a shrinking divide never overflows
// because the terminal test is a greater-or-equal compare.
module wdg_prescaler #(
    parameter int PR_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic            clr,
    input  logic [PR_W-1:0] pr,
    output logic            tick
);
    localparam int DIV_W = 3 + (1 << PR_W) - 1;

    logic [DIV_W-1:0] pre_q;
    logic [DIV_W-1:0] div_m1;

    assign div_m1 = (DIV_W'(4) << pr) - DIV_W'(1);
    assign tick   = en && !clr && (pre_q >= div_m1);

    // Phase counter, wrapping at the selected divide.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !en) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/wdg_core.sv
// Slow-clock side: takes configuration from the bus shadows, runs the
// down-counter, checks the refresh window and issues the reset pulse.
// Assumes bus-side toggles are spaced so each is seen once.
module wdg_core
    import wdg_pkg::*;
#(
    parameter int PR_W        = 3,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CH-1:0]  req_tgl_i,
    input  logic             start_tgl_i,
    input  logic             refresh_tgl_i,
    input  logic [PR_W-1:0]  pr_i,
    input  logic [CNT_W-1:0] rl_i,
    input  logic [CNT_W-1:0] win_i,
    output logic [N_CH-1:0]  ack_tgl_o,
    output logic             running_o,
    output logic             wdt_rst_o
);
    logic [N_CH+1:0]  sync_s;
    logic [N_CH-1:0]  req_s;
    logic [N_CH-1:0]  ack_q;
    logic [N_CH-1:0]  capture;
    logic             start_seen_q, refresh_seen_q;
    logic             start_ev, refresh_ev, kick, early, fire, tick;
    logic [PR_W-1:0]  pr_act;
    logic [CNT_W-1:0] rl_act, win_act, cnt_q;
    logic             running_q, rst_q;

    wdg_sync #(.WIDTH(N_CH + 2), .STAGES(SYNC_STAGES)) u_in_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({refresh_tgl_i, start_tgl_i, req_tgl_i}),
        .q     (sync_s)
    );

    assign req_s      = sync_s[N_CH-1:0];
    assign capture    = req_s ^ ack_q;
    assign start_ev   = sync_s[N_CH] ^ start_seen_q;
    assign refresh_ev = (sync_s[N_CH+1] ^ refresh_seen_q) && running_q;
    assign kick       = start_ev || refresh_ev;
    assign early      = refresh_ev && (cnt_q > win_act);
    assign fire       = early || (tick && (cnt_q == '0));

    wdg_prescaler #(.PR_W(PR_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (running_q),
        .clr   (kick),
        .pr    (pr_act),
        .tick  (tick)
    );

    // Copy a shadow value when its request toggle arrives, then acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= '0;
            pr_act  <= '0;
            rl_act  <= '1;
            win_act <= '1;
        end else begin
            ack_q <= req_s;
            if (capture[CH_PR])  pr_act  <= pr_i;
            if (capture[CH_RL])  rl_act  <= rl_i;
            if (capture[CH_WIN]) win_act <= win_i;
        end
    end

    // Start/refresh edge tracking, down-counter and reset pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_seen_q   <= 1'b0;
            refresh_seen_q <= 1'b0;
            running_q      <= 1'b0;
            cnt_q          <= '1;
            rst_q          <= 1'b0;
        end else begin
            start_seen_q   <= sync_s[N_CH];
            refresh_seen_q <= sync_s[N_CH+1];
            rst_q          <= fire;
            if (start_ev) begin
                running_q <= 1'b1;
                cnt_q     <= rl_act;
            end else if (refresh_ev) begin
                cnt_q <= rl_act;
            end else if (tick) begin
                cnt_q <= (cnt_q == '0) ? rl_act : cnt_q - CNT_W'(1);
            end
        end
    end

    assign ack_tgl_o = ack_q;
    assign running_o = running_q;
    assign wdt_rst_o = rst_q;
endmodule

// File: rtl/keyed_wdt.sv
// Top level of the keyed watchdog: bus-clock register port on one side,
// slow-clock counter on the other. rst_n must be held across at least
// SYNC_STAGES+1 slow edges so both domains see it.
module keyed_wdt
    import wdg_pkg::*;
#(
    parameter int PR_W        = 3,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_clk,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [KEY_W-1:0] wr_data,
    output logic [N_CH-1:0]  busy_o,
    output logic             running_o,
    output logic             wdt_rst_o
);
    logic [N_CH-1:0]  req_tgl_w, ack_tgl_w;
    logic             start_tgl_w, refresh_tgl_w, unlocked_w;
    logic [PR_W-1:0]  pr_w;
    logic [CNT_W-1:0] rl_w, win_w;

    wdg_bus_if #(.PR_W(PR_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_bus (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .ack_tgl_i     (ack_tgl_w),
        .req_tgl_o     (req_tgl_w),
        .start_tgl_o   (start_tgl_w),
        .refresh_tgl_o (refresh_tgl_w),
        .pr_o          (pr_w),
        .rl_o          (rl_w),
        .win_o         (win_w),
        .busy_o        (busy_o),
        .unlocked_o    (unlocked_w)
    );

    wdg_core #(.PR_W(PR_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_core (
        .clk           (slow_clk),
        .rst_n         (rst_n),
        .req_tgl_i     (req_tgl_w),
        .start_tgl_i   (start_tgl_w),
        .refresh_tgl_i (refresh_tgl_w),
        .pr_i          (pr_w),
        .rl_i          (rl_w),
        .win_i         (win_w),
        .ack_tgl_o     (ack_tgl_w),
        .running_o     (running_o),
        .wdt_rst_o     (wdt_rst_o)
    );
endmodule

// File: rtl/wdg_checker.sv
// Protocol and timing properties of the keyed watchdog, bound to the top.
module wdg_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             slow_clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             unlocked,
    input logic [2:0]       busy,
    input logic [CNT_W-1:0] rl_shadow,
    input logic             running,
    input logic             wdt_rst
);
    // R1: a closed register write never raises a busy bit.
    p_locked_write_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 2'd0 && !unlocked) |=> ((busy & ~$past(busy)) == 3'b000));

    // R2: once running, the watchdog stays running.
    p_start_sticky_r2: assert property (@(posedge slow_clk) disable iff (!rst_n)
        running |=> running);

    // R3: no reset request before the watchdog has been started.
    p_no_reset_idle_r3: assert property (@(posedge slow_clk) disable iff (!rst_n)
        !running |-> !wdt_rst);

    // R7: an accepted reload write raises its busy bit on the next edge.
    p_busy_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && unlocked && !busy[1]) |=> busy[1]);

    // R8: a reload write during a pending transfer keeps the pending value.
    p_pending_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd2 && busy[1]) |=> $stable(rl_shadow));

    // R10: the reset request is a single slow-cycle pulse.
    p_pulse_single_r10: assert property (@(posedge slow_clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);
endmodule

bind keyed_wdt wdg_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .slow_clk  (slow_clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .unlocked  (unlocked_w),
    .busy      (busy_o),
    .rl_shadow (rl_w),
    .running   (running_o),
    .wdt_rst   (wdt_rst_o)
);

// File: tb/keyed_wdt_test.sv
`timescale 1ns/1ps
module keyed_wdt_test;
    logic        clk = 1'b0;
    logic        slow_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [2:0]  busy_o;
    logic        running_o;
    logic        wdt_rst_o;

    int checks = 0;
    int fails  = 0;
    int slow_cyc = 0;
    int pulse_cnt = 0;
    int last_pulse = 0;
    bit prev_rst = 1'b0;
    bit long_pulse = 1'b0;

    // Table rows: prescaler field, reload value, expected period (slow cycles).
    localparam int NV = 5;
    localparam int TBL [NV][3] = '{
        '{0, 10, 44}, '{1, 10, 88}, '{2, 3, 64}, '{0, 0, 4}, '{3, 2, 96}
    };

    keyed_wdt uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_clk  (slow_clk),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .busy_o    (busy_o),
        .running_o (running_o),
        .wdt_rst_o (wdt_rst_o)
    );

    always #2.5 clk = ~clk;
    always #10  slow_clk = ~slow_clk;

    always @(posedge slow_clk) slow_cyc <= slow_cyc + 1;

    // Pulse monitor, sampled away from the active slow edge.
    always @(negedge slow_clk) begin
        if (wdt_rst_o) begin
            pulse_cnt  = pulse_cnt + 1;
            last_pulse = slow_cyc;
            if (prev_rst) long_pulse = 1'b1;
        end
        prev_rst = wdt_rst_o;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy_o != 3'b000 && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(busy_o == 3'b000, req, int'(busy_o), 0);
    endtask

    task automatic wait_pulse(input int limit, output bit seen, output int at);
        int base = pulse_cnt;
        seen = 1'b0;
        at = 0;
        for (int i = 0; i < limit && !seen; i++) begin
            @(negedge slow_clk);
            #1;
            if (pulse_cnt != base) begin
                seen = 1'b1;
                at = last_pulse;
            end
        end
    endtask

    task automatic count_pulses(input int n, output int got);
        int base = pulse_cnt;
        repeat (n) @(negedge slow_clk);
        #1;
        got = pulse_cnt - base;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit seen;
        int t0, p1, p2, p3, got;

        repeat (5) @(negedge slow_clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(busy_o == 3'b000, "R9 busy", int'(busy_o), 0);
        check(running_o == 1'b0, "R9 running", int'(running_o), 0);
        check(wdt_rst_o == 1'b0, "R9 pulse", int'(wdt_rst_o), 0);

        // R1: write while closed is ignored
        wr(2'd2, 16'd5);
        check(busy_o == 3'b000, "R1 closed write", int'(busy_o), 0);

        // R2 / R9: start from reset defaults, first timeout ~ 4096*4
        t0 = slow_cyc;
        wr(2'd0, 16'hCCCC);
        repeat (10) @(negedge slow_clk);
        check(running_o == 1'b1, "R2 running", int'(running_o), 1);
        wait_pulse(17000, seen, p1);
        check(seen && (p1 - t0) >= 16384 && (p1 - t0) <= 16396, "R9 default period",
              p1 - t0, 16384);

        // R3 R4 R7: table of configurations, exact period measurement
        for (int v = 0; v < NV; v++) begin
            wr(2'd0, 16'h5555);
            wr(2'd1, 16'(TBL[v][0]));
            check(busy_o[0] == 1'b1, "R7 busy prescaler", int'(busy_o[0]), 1);
            wr(2'd2, 16'(TBL[v][1]));
            check(busy_o[1] == 1'b1, "R7 busy reload", int'(busy_o[1]), 1);
            wait_idle("R7 status clears");
            wr(2'd0, 16'hAAAA);
            wait_pulse(2000, seen, p1);
            wait_pulse(2000, seen, p2);
            wait_pulse(2000, seen, p3);
            check(seen && (p3 - p2) == TBL[v][2], "R3 R4 period", p3 - p2, TBL[v][2]);
        end

        // R8: second reload write while busy is dropped
        wr(2'd0, 16'h5555);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd10);
        wr(2'd2, 16'd50);
        check(busy_o[1] == 1'b1, "R8 still pending", int'(busy_o[1]), 1);
        wait_idle("R7 idle after R8");
        wr(2'd0, 16'hAAAA);
        wait_pulse(2000, seen, p1);
        wait_pulse(2000, seen, p2);
        wait_pulse(2000, seen, p3);
        check(seen && (p3 - p2) == 44, "R8 period keeps first value", p3 - p2, 44);

        // R6 setup: window 5, relock with a foreign key (R1)
        wr(2'd0, 16'h5555);
        wr(2'd3, 16'd5);
        check(busy_o[2] == 1'b1, "R7 busy window", int'(busy_o[2]), 1);
        wait_idle("R7 idle window");
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'd7);
        check(busy_o == 3'b000, "R1 foreign key relocks", int'(busy_o), 0);

        // R6: refresh right after a timeout, counter above window -> pulse
        wait_pulse(200, seen, p1);
        wr(2'd0, 16'hAAAA);
        wait_pulse(16, seen, p2);
        check(seen, "R6 early refresh pulse", int'(seen), 1);

        // R5: refresh inside the window postpones the timeout
        wait_pulse(200, seen, p1);
        repeat (30) @(negedge slow_clk);
        wr(2'd0, 16'hAAAA);
        count_pulses(40, got);
        check(got == 0, "R5 refresh postpones", got, 0);
        wait_pulse(30, seen, p2);
        check(seen, "R5 pulse after full period", int'(seen), 1);

        // R6: window 12'hFFF disables the early check
        wr(2'd0, 16'h5555);
        wr(2'd3, 16'hFFF);
        wait_idle("R7 idle window off");
        wr(2'd0, 16'hAAAA);
        wait_pulse(200, seen, p1);
        wr(2'd0, 16'hAAAA);
        count_pulses(30, got);
        check(got == 0, "R6 window disabled", got, 0);

        // R2: start key relocks; unlock key does not stop the watchdog
        wr(2'd0, 16'h5555);
        wr(2'd0, 16'hCCCC);
        wr(2'd2, 16'd3);
        check(busy_o == 3'b000, "R2 start relocks", int'(busy_o), 0);
        wr(2'd0, 16'h5555);
        repeat (10) @(negedge slow_clk);
        check(running_o == 1'b1, "R2 still running", int'(running_o), 1);

        // R10: no pulse ever spanned two slow cycles
        check(long_pulse == 1'b0, "R10 pulse width", int'(long_pulse), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule